// File: doc/BRIEF.md
# Synchronous FIFO with Loadable Threshold Offsets

This block is a single-clock FIFO, 4096 words deep and 9 bits wide. It raises an almost-empty warning and an almost-full warning, and the thresholds for both are set from the data bus. Each threshold is a 12-bit offset. Each offset is split over two byte-wide slots: a low slot for bits 7:0 and a high slot for bits 11:8. That makes four slots, and one shared 2-bit pointer selects among them.

Holding the load input low changes what the ordinary enables do. A write then stores the data bus into the selected slot. A read then copies the selected slot onto the data output. Either action advances the pointer.

The pointer keeps its place when the load input is raised again. A partial load can therefore be finished in a later session. Only a master reset sends the pointer back to the first slot. When the load input is high, the block behaves as a plain FIFO.

Top module: `offset_fifo`

## Requirements
- R1: The asynchronous active-low reset `rstN` empties the FIFO and sets both offsets to 7. The low slots hold 0x07 and the high slots hold 0. The pointer returns to slot 0. After reset `empty`=1, `full`=0, `almostEmpty`=1 and `almostFull`=0.
- R2: With `loadN`=0 and `wrEnN`=0, each rising edge stores `dataIn` into the slot the pointer selects, then advances the pointer. Slot 0 is empty-offset bits 7:0 and takes `dataIn[7:0]`. Slot 1 is empty-offset bits 11:8 and takes `dataIn[3:0]`. Slot 2 is full-offset bits 7:0. Slot 3 is full-offset bits 11:8. After slot 3 the pointer wraps to slot 0.
- R3: Raising `loadN` does not move the pointer. The next load write goes to the slot after the last one used. Load writes never enter the FIFO.
- R4: With `loadN`=0, `rdEnAN`=0 and `rdEnBN`=0, each rising edge places the selected slot on `dataOut` and advances the pointer. The value is zero-extended, so bits above the slot's width read 0.
- R5: A load write and a readback requested on the same edge perform only the write. `dataOut` is unchanged and the pointer advances once.
- R6: With `loadN`=1, `wrEnN`=0 pushes `dataIn` onto the FIFO. Both read enables low pops the oldest word onto `dataOut` at that edge. Words leave in the order they arrived.
- R7: A push while `full` is ignored. A pop while `empty` is ignored and leaves `dataOut` unchanged.
- R8: `almostEmpty` is a register. It is 1 when the word count after the edge is at or below the empty offset.
- R9: `almostFull` is a register. It is 1 when the free space after the edge (4096 minus the count) is at or below the full offset.
- R10: A read is performed only when both `rdEnAN` and `rdEnBN` are low. With only one of them low, neither a pop nor a readback happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both write and read sides |
| rstN | input | 1 | Asynchronous master reset, active low |
| loadN | input | 1 | Low selects the offset slots; high selects normal FIFO operation |
| wrEnN | input | 1 | Write enable, active low |
| rdEnAN | input | 1 | First read enable, active low |
| rdEnBN | input | 1 | Second read enable, active low |
| dataIn | input | 9 | FIFO write data or offset load data |
| dataOut | output | 9 | FIFO read data or offset readback, registered |
| empty | output | 1 | FIFO holds no words |
| full | output | 1 | FIFO holds 4096 words |
| almostEmpty | output | 1 | Count at or below the empty offset |
| almostFull | output | 1 | Free space at or below the full offset |

## Verification
The bench walks the pointer through a partial session, an idle gap and a wrap. A pointer that restarts on each session would land in the wrong slot, and the readback that follows would expose it. A same-edge load and read is driven to catch a design that lets the readback through or steps the pointer twice. A read with a single enable low is driven to catch a design that decodes only one enable. The thresholds are probed one word either side of the default and a loaded offset. A comparison that is off by one moves the flag a word early or late. Finally the FIFO is filled past capacity and drained completely. A design that accepts a push when full, or loses ordering across the pointer wrap, returns wrong words or the wrong count.

// File: rtl/offset_fifo_pkg.sv
package offset_fifo_pkg;
  // Per-edge commands from the control to the datapath.
  typedef struct packed {
    logic       push;   // store a word into the FIFO
    logic       pop;    // move the oldest word to the output
    logic       offWr;  // load the selected offset slot
    logic       offRd;  // read the selected offset slot back
    logic [1:0] ptr;    // selected offset slot
  } strobe_t;
endpackage

// File: rtl/offset_fifo_ctrl.sv
module offset_fifo_ctrl
  import offset_fifo_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadN,
  input  logic    wrEnN,
  input  logic    rdEnAN,
  input  logic    rdEnBN,
  input  logic    empty,
  input  logic    full,
  output strobe_t strb
);
  logic [1:0] slotPtr;
  logic       rdReq;
  logic       wrReq;

  assign rdReq = !rdEnAN && !rdEnBN;
  assign wrReq = !wrEnN;

  always_comb begin
    strb.offWr = !loadN && wrReq;
    // A load on the same edge wins; the readback is dropped.
    strb.offRd = !loadN && rdReq && !wrReq;
    strb.push  = loadN && wrReq && !full;
    strb.pop   = loadN && rdReq && !empty;
    strb.ptr   = slotPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         slotPtr <= 2'd0;
    else if (strb.offWr || strb.offRd) slotPtr <= slotPtr + 2'd1;
  end

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.offWr || strb.offRd) |=> slotPtr == $past(slotPtr) + 2'd1);
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.offWr || strb.offRd) |=> $stable(slotPtr));
  p_one_access_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.offWr, strb.offRd}));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strb.push);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !strb.pop);
endmodule

// File: rtl/offset_fifo_dp.sv
module offset_fifo_dp
  import offset_fifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 12,
  parameter int LO_W    = 8,
  parameter int DEF_OFF = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              empty,
  output logic              full,
  output logic              almostEmpty,
  output logic              almostFull
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - LO_W;
  localparam logic [ADDR_W:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [ADDR_W:0]   count, countNext;
  logic [LO_W-1:0]   offSlot [4];
  logic [ADDR_W-1:0] emptyOff, fullOff;

  // Even slots hold bits LO_W-1:0, odd slots hold the remaining upper bits.
  for (genvar i = 0; i < 4; i++) begin : g_slot
    if (i % 2 == 0) begin : g_lo
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) offSlot[i] <= LO_W'(DEF_OFF);
        else if (strb.offWr && strb.ptr == 2'(i)) offSlot[i] <= dataIn[LO_W-1:0];
      end
    end else begin : g_hi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) offSlot[i] <= '0;
        else if (strb.offWr && strb.ptr == 2'(i)) offSlot[i] <= LO_W'(dataIn[HI_W-1:0]);
      end
    end
  end

  assign emptyOff = {offSlot[1][HI_W-1:0], offSlot[0]};
  assign fullOff  = {offSlot[3][HI_W-1:0], offSlot[2]};

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= dataIn;
  end

  always_comb begin
    countNext = count;
    if (strb.push && !strb.pop)      countNext = count + 1'b1;
    else if (strb.pop && !strb.push) countNext = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      count       <= '0;
      dataOut     <= '0;
      almostEmpty <= 1'b1;
      almostFull  <= 1'b0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop) begin
        rdPtr   <= rdPtr + 1'b1;
        dataOut <= mem[rdPtr];
      end else if (strb.offRd) begin
        dataOut <= {{(DATA_W-LO_W){1'b0}}, offSlot[strb.ptr]};
      end
      count       <= countNext;
      almostEmpty <= countNext <= {1'b0, emptyOff};
      almostFull  <= (DEPTH_V - countNext) <= {1'b0, fullOff};
    end
  end

  assign empty = (count == '0);
  assign full  = count[ADDR_W];

  p_count_up_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop) |=> count == $past(count) + 1'b1);
  p_count_down_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push) |=> count == $past(count) - 1'b1);
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pop || strb.offRd) |=> $stable(dataOut));
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full));
endmodule

// File: rtl/offset_fifo.sv
module offset_fifo
  import offset_fifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 12,
  parameter int LO_W    = 8,
  parameter int DEF_OFF = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              wrEnN,
  input  logic              rdEnAN,
  input  logic              rdEnBN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              empty,
  output logic              full,
  output logic              almostEmpty,
  output logic              almostFull
);
  strobe_t strb;

  offset_fifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadN(loadN), .wrEnN(wrEnN),
    .rdEnAN(rdEnAN), .rdEnBN(rdEnBN), .empty(empty), .full(full),
    .strb(strb)
  );

  offset_fifo_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_W(LO_W), .DEF_OFF(DEF_OFF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .dataOut(dataOut), .empty(empty), .full(full),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );
endmodule

// File: tb/offset_fifo_tb.sv
module offset_fifo_tb;
  localparam int DEPTH = 4096;
  localparam int NVEC  = 18;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadN = 1'b1, wrEnN = 1'b1, rdEnAN = 1'b1, rdEnBN = 1'b1;
  logic [8:0] dataIn = '0;
  logic [8:0] dataOut;
  logic       empty, full, almostEmpty, almostFull;
  int         nRun = 0, nFail = 0;
  bit         done = 0;

  offset_fifo u_dut (
    .clk(clk), .rstN(rstN), .loadN(loadN), .wrEnN(wrEnN),
    .rdEnAN(rdEnAN), .rdEnBN(rdEnBN), .dataIn(dataIn), .dataOut(dataOut),
    .empty(empty), .full(full), .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

  always #2 clk = ~clk;

  // Vector layout: {loadN, wrEnN, rdEnAN, rdEnBN, dataIn[8:0], expected dataOut[8:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {4'b0100, 9'h000, 9'h007},  // R1/R4 default empty lo
    {4'b0100, 9'h000, 9'h000},  // R1/R4 default empty hi
    {4'b0100, 9'h000, 9'h007},  // R1/R4 default full lo
    {4'b0100, 9'h000, 9'h000},  // R1/R4 default full hi, wraps
    {4'b0011, 9'h1A5, 9'h000},  // R2 slot0 <= A5, bit 8 dropped
    {4'b0011, 9'h0F3, 9'h000},  // R2 slot1 <= 3
    {4'b0011, 9'h010, 9'h000},  // R2 slot2 <= 10
    {4'b1111, 9'h000, 9'h000},  // R3 session ends
    {4'b0011, 9'h1FE, 9'h000},  // R3 resumes at slot3 <= E
    {4'b0011, 9'h020, 9'h000},  // R2 wrap to slot0 <= 20
    {4'b0100, 9'h000, 9'h003},  // R4 slot1
    {4'b0100, 9'h000, 9'h010},  // R4 slot2
    {4'b0100, 9'h000, 9'h00E},  // R4 slot3 upper bits zero
    {4'b0100, 9'h000, 9'h020},  // R4 slot0
    {4'b0000, 9'h004, 9'h020},  // R5 load wins, output holds
    {4'b0100, 9'h000, 9'h010},  // R5 pointer stepped once
    {4'b0101, 9'h000, 9'h010},  // R10 single enable, nothing read
    {4'b0100, 9'h000, 9'h00E}   // R10 pointer did not move
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle's inputs, let the edge pass, sample 1 ns later.
  task automatic step(input logic [3:0] ctl, input logic [8:0] d);
    {loadN, wrEnN, rdEnAN, rdEnBN} = ctl;
    dataIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {loadN, wrEnN, rdEnAN, rdEnBN} = 4'b1111;
    #5;
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [8:0] d);
    step(4'b1011, d);
  endtask

  initial begin
    #800_000;
    if (!done) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 empty", {8'd0, empty}, 9'd1);
    check("R1 full", {8'd0, full}, 9'd0);
    check("R1 almostEmpty", {8'd0, almostEmpty}, 9'd1);
    check("R1 almostFull", {8'd0, almostFull}, 9'd0);

    // Vector walk: load and readback sequencing
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][21:18], VEC[i][17:9]);
      check($sformatf("R2-vec%0d dataOut", i), dataOut, VEC[i][8:0]);
      check($sformatf("R3 vec%0d no FIFO write", i), {8'd0, empty}, 9'd1);
    end

    // R1: mid-session reset restores slot 0 and defaults
    doReset();
    step(4'b0100, 9'h000);
    check("R1 pointer and default after reset", dataOut, 9'h007);

    // R6 ordering, R7 pop on empty, R10 single enable
    doReset();
    push(9'h101); push(9'h055); push(9'h0AA);
    step(4'b1100, 9'h000); check("R6 pop 1", dataOut, 9'h101);
    step(4'b1100, 9'h000); check("R6 pop 2", dataOut, 9'h055);
    step(4'b1100, 9'h000); check("R6 pop 3", dataOut, 9'h0AA);
    check("R6 empty after drain", {8'd0, empty}, 9'd1);
    step(4'b1100, 9'h000); check("R7 pop on empty holds", dataOut, 9'h0AA);
    push(9'h033);
    step(4'b1101, 9'h000); check("R10 rdEnBN high no pop", dataOut, 9'h0AA);
    step(4'b1110, 9'h000); check("R10 rdEnAN high no pop", dataOut, 9'h0AA);
    check("R10 word kept", {8'd0, empty}, 9'd0);
    step(4'b1100, 9'h000); check("R10 word then pops", dataOut, 9'h033);

    // R8 default offset boundary 7/8
    doReset();
    for (int i = 0; i < 7; i++) push(9'(i));
    check("R8 count 7 at offset 7", {8'd0, almostEmpty}, 9'd1);
    push(9'h007);
    check("R8 count 8 above offset 7", {8'd0, almostEmpty}, 9'd0);

    // R8 with loaded empty offset 2
    doReset();
    step(4'b0011, 9'h002);
    step(4'b1111, 9'h000);
    push(9'h000); push(9'h001);
    check("R8 count 2 at offset 2", {8'd0, almostEmpty}, 9'd1);
    push(9'h002);
    check("R8 count 3 above offset 2", {8'd0, almostEmpty}, 9'd0);

    // R9 almost-full boundary, R7 overflow, R6 full-depth order
    doReset();
    for (int i = 0; i < DEPTH - 8; i++) push(9'(i));
    check("R9 free 8 above offset 7", {8'd0, almostFull}, 9'd0);
    push(9'(DEPTH - 8));
    check("R9 free 7 at offset 7", {8'd0, almostFull}, 9'd1);
    for (int i = DEPTH - 7; i < DEPTH; i++) push(9'(i));
    check("R7 full at depth", {8'd0, full}, 9'd1);
    push(9'h1AB);
    check("R7 full after ignored push", {8'd0, full}, 9'd1);
    begin
      int bad = 0;
      logic [8:0] firstBad = '0, firstExp = '0;
      for (int i = 0; i < DEPTH; i++) begin
        step(4'b1100, 9'h000);
        if (dataOut !== 9'(i) && bad == 0) begin
          firstBad = dataOut;
          firstExp = 9'(i);
        end
        if (dataOut !== 9'(i)) bad++;
      end
      check("R6 full-depth order", firstBad, firstExp);
    end
    check("R7 empty after draining exactly depth", {8'd0, empty}, 9'd1);
    step(4'b1100, 9'h000);
    check("R7 pop on empty after drain", dataOut, 9'(DEPTH - 1));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule